// File: doc/BRIEF.md
# Wavefront Access Coalescer

This unit sits between per-lane address generation and a cache or memory request port. One quarter of a wavefront (16 lanes, each with its own byte address and an enable bit) is offered per handshake, together with an element size of 32 or 64 bits and a load/store flag. The unit checks whether the enabled lanes form a contiguous, line-aligned run. If they do, it packs them into 64-byte line requests: one request for a 32-bit quarter, and two for a 64-bit quarter, one for each half of eight lanes. If they do not, it falls back to per-lane addressing and issues four beats. Each of those beats carries the individual addresses of four consecutive lanes.

Each quarter therefore costs a fixed 1, 2 or 4 issue cycles. A 64-lane wavefront costs 4 cycles when it is 32-bit and packed, 8 when it is 64-bit and packed, and 16 when nothing packs. Loads and stores are packed by the same rule. Every line request carries the line address, a 64-bit byte-enable mask and a 6-bit byte offset for every lane, so that returned or written data can be steered to and from the lanes.

The control is a four-state machine. ST_IDLE waits for a quarter. ST_LINE32 issues one line beat. ST_LINE64 issues two line beats. ST_SCALAR issues four per-lane beats. From ST_IDLE an accepted quarter moves the machine to the state for its class. From any busy state the final beat either accepts the next quarter (moving to that quarter's class state) or returns to ST_IDLE. A busy state holds its place while beats remain.

Top module: `cw_coalescer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: With in_wide=0, if every enabled lane j has address L+4*j and L is a multiple of 64, the quarter issues exactly one beat in the cycle after acceptance. That beat has out_line=1 and out_line_addr=L. out_lane_off for lane j (bits 6j+5:6j) is 4*j. out_be bits 4j..4j+3 are set for each enabled lane and no others are set.
- R3: With in_wide=1, lanes 0-7 form half 0 and lanes 8-15 form half 1. Lane j sits at index i=j mod 8 within its half. If every enabled lane of half h has address L_h+8*i with each L_h a multiple of 64, the quarter issues two line beats, half 0 first. Beat h has out_line_addr=L_h, offset 8*i for each lane of that half, out_be bits 8i..8i+7 set, and out_lane_en limited to that half.
- R4: A quarter that fails the rule of R2/R3 issues four beats with out_line=0. Beat k covers lanes 4k..4k+3, and out_slot_addr slot i (bits AW*i+AW-1:AW*i) holds lane 4k+i's address. out_be and out_lane_off are zero in these beats.
- R5: A quarter occupies exactly 1, 2 or 4 issue cycles (R2, R3, R4 respectively). in_ready is 1 only in idle or on the final beat. With input always offered, a wavefront of four quarters therefore takes 4, 8 or 16 cycles.
- R6: A disabled lane's address has no effect on the class, and the lane appears in neither out_lane_en nor out_be. A beat with no enabled lane still takes its cycle, but shows out_valid=0.
- R7: out_store repeats the accepted flag on every beat, and the packing is identical for loads and stores.
- R8: An address run that is contiguous but whose base is not a multiple of 64 (for example 16-byte aligned), or a run with any single enabled lane out of place, uses the per-lane path of R4.
- R9: out_wide repeats the accepted element size on every beat of the quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A quarter is offered |
| in_ready | output | 1 | The offered quarter is taken at this clock edge |
| in_wide | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| in_store | input | 1 | 1 = store, 0 = load |
| in_mask | input | 16 | Lane enables |
| in_addr | input | 16*AW | Lane byte addresses, lane j at bits AW*j+AW-1:AW*j |
| out_valid | output | 1 | The current beat carries a request |
| out_line | output | 1 | 1 = line request, 0 = per-lane request |
| out_wide | output | 1 | Element size of the quarter being issued |
| out_store | output | 1 | Load/store flag of the quarter being issued |
| out_line_addr | output | AW | 64-byte aligned line address (line beats) |
| out_be | output | 64 | Byte enables within the line (line beats) |
| out_lane_en | output | 16 | Lanes served by this beat |
| out_lane_off | output | 96 | Byte offset in the line for each lane, 6 bits per lane |
| out_slot_addr | output | 4*AW | Per-lane addresses of the four lanes of a per-lane beat |

## Verification
The quarter is taken at the rising edge where in_valid and in_ready are both high. Beat b of that quarter is shown during the b-th cycle after that edge, so beat 0 is due one cycle after acceptance, and in_ready rises on the last beat. The bench drives inputs and samples all outputs on falling edges. It compares beat b on the b-th falling edge after acceptance, then checks for idle one cycle after the last beat. For wavefront timing it counts rising edges between the first accepted quarter and the acceptance of a trailing filler quarter, which must be 4, 8 or 16 edges later.

// File: rtl/cw_pkg.sv
package cw_pkg;
    localparam int QUARTER    = 16;
    localparam int HALF       = QUARTER / 2;
    localparam int SLOTS      = 4;
    localparam int LINE_BYTES = 64;
    localparam int OFF_W      = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LINE32 = 2'd1,
        ST_LINE64 = 2'd2,
        ST_SCALAR = 2'd3
    } cw_state_e;
endpackage

// File: rtl/cw_classify.sv
module cw_classify
    import cw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [QUARTER*AW-1:0] addr,
    input  logic [QUARTER-1:0]    mask,
    input  logic                  wide,
    output logic                  ok,
    output logic [AW-1:0]         base0,
    output logic [AW-1:0]         base1
);
    logic [AW-1:0]      ref_q [2];
    logic [1:0]         found;
    logic [QUARTER-1:0] lane_ok;

    // Segment base taken from the first enabled lane of each segment
    always_comb begin
        found    = '0;
        ref_q[0] = '0;
        ref_q[1] = '0;
        for (int j = 0; j < QUARTER; j++) begin
            if (mask[j]) begin
                if (wide) begin
                    if (!found[j/HALF]) begin
                        found[j/HALF] = 1'b1;
                        ref_q[j/HALF] = addr[j*AW +: AW] - AW'((j % HALF) * 8);
                    end
                end else if (!found[0]) begin
                    found[0] = 1'b1;
                    ref_q[0] = addr[j*AW +: AW] - AW'(j * 4);
                end
            end
        end
    end

    for (genvar j = 0; j < QUARTER; j++) begin : g_lane
        localparam int SJ = j / HALF;
        localparam int IW = j % HALF;
        logic [AW-1:0] exp_n;
        logic [AW-1:0] exp_w;
        assign exp_n      = ref_q[0] + AW'(j * 4);
        assign exp_w      = ref_q[SJ] + AW'(IW * 8);
        assign lane_ok[j] = !mask[j] || (addr[j*AW +: AW] == (wide ? exp_w : exp_n));
    end

    assign ok = (&lane_ok)
             && (!found[0] || (ref_q[0][OFF_W-1:0] == '0))
             && (!found[1] || (ref_q[1][OFF_W-1:0] == '0));
    assign base0 = ref_q[0];
    assign base1 = ref_q[1];
endmodule

// File: rtl/cw_beat_gen.sv
module cw_beat_gen
    import cw_pkg::*;
#(
    parameter int AW = 32
) (
    input  cw_state_e                 state,
    input  logic [1:0]                beat,
    input  logic [QUARTER*AW-1:0]     addr,
    input  logic [QUARTER-1:0]        mask,
    input  logic [AW-1:0]             base0,
    input  logic [AW-1:0]             base1,
    output logic                      valid,
    output logic                      line,
    output logic [AW-1:0]             line_addr,
    output logic [LINE_BYTES-1:0]     be,
    output logic [QUARTER-1:0]        lane_en,
    output logic [QUARTER*OFF_W-1:0]  lane_off,
    output logic [SLOTS*AW-1:0]       slot_addr
);
    always_comb begin
        line      = 1'b0;
        line_addr = '0;
        be        = '0;
        lane_en   = '0;
        lane_off  = '0;
        slot_addr = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_LINE32: begin
                line      = 1'b1;
                line_addr = base0;
                for (int j = 0; j < QUARTER; j++) begin
                    if (mask[j]) begin
                        lane_en[j]                 = 1'b1;
                        lane_off[j*OFF_W +: OFF_W] = OFF_W'(j * 4);
                        for (int b = 0; b < 4; b++) be[j*4 + b] = 1'b1;
                    end
                end
            end
            ST_LINE64: begin
                line      = 1'b1;
                line_addr = beat[0] ? base1 : base0;
                for (int j = 0; j < QUARTER; j++) begin
                    if (mask[j] && ((j / HALF) == int'(beat[0]))) begin
                        lane_en[j]                 = 1'b1;
                        lane_off[j*OFF_W +: OFF_W] = OFF_W'((j % HALF) * 8);
                        for (int b = 0; b < 8; b++) be[(j % HALF)*8 + b] = 1'b1;
                    end
                end
            end
            ST_SCALAR: begin
                for (int j = 0; j < QUARTER; j++) begin
                    if (mask[j] && ((j / SLOTS) == int'(beat))) begin
                        lane_en[j]                          = 1'b1;
                        slot_addr[(j % SLOTS)*AW +: AW]     = addr[j*AW +: AW];
                    end
                end
            end
            default: begin
            end
        endcase
        valid = |lane_en;
    end
endmodule

// File: rtl/cw_coalescer.sv
module cw_coalescer
    import cw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_wide,
    input  logic                      in_store,
    input  logic [QUARTER-1:0]        in_mask,
    input  logic [QUARTER*AW-1:0]     in_addr,
    output logic                      out_valid,
    output logic                      out_line,
    output logic                      out_wide,
    output logic                      out_store,
    output logic [AW-1:0]             out_line_addr,
    output logic [LINE_BYTES-1:0]     out_be,
    output logic [QUARTER-1:0]        out_lane_en,
    output logic [QUARTER*OFF_W-1:0]  out_lane_off,
    output logic [SLOTS*AW-1:0]       out_slot_addr
);
    cw_state_e             state, nxt_state, cls;
    logic [1:0]            beat, nxt_beat;
    logic                  last, accept, pack_ok;
    logic [AW-1:0]         c_base0, c_base1;

    logic [QUARTER*AW-1:0] q_addr;
    logic [QUARTER-1:0]    q_mask;
    logic                  q_wide, q_store;
    logic [AW-1:0]         q_base0, q_base1;

    cw_classify #(.AW(AW)) u_cls (
        .addr  (in_addr),
        .mask  (in_mask),
        .wide  (in_wide),
        .ok    (pack_ok),
        .base0 (c_base0),
        .base1 (c_base1)
    );

    assign cls = !pack_ok ? ST_SCALAR : (in_wide ? ST_LINE64 : ST_LINE32);

    assign last = (state == ST_LINE32)
               || (state == ST_LINE64 && beat == 2'd1)
               || (state == ST_SCALAR && beat == 2'd3);
    assign in_ready = (state == ST_IDLE) || last;
    assign accept   = in_valid && in_ready;

    always_comb begin
        nxt_state = state;
        nxt_beat  = beat;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    nxt_state = cls;
                    nxt_beat  = '0;
                end
            end
            ST_LINE32, ST_LINE64, ST_SCALAR: begin
                if (last) begin
                    nxt_state = in_valid ? cls : ST_IDLE;
                    nxt_beat  = '0;
                end else begin
                    nxt_beat = beat + 2'd1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= nxt_state;
            beat  <= nxt_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_mask  <= '0;
            q_wide  <= 1'b0;
            q_store <= 1'b0;
            q_base0 <= '0;
            q_base1 <= '0;
        end else if (accept) begin
            q_addr  <= in_addr;
            q_mask  <= in_mask;
            q_wide  <= in_wide;
            q_store <= in_store;
            q_base0 <= c_base0;
            q_base1 <= c_base1;
        end
    end

    cw_beat_gen #(.AW(AW)) u_gen (
        .state     (state),
        .beat      (beat),
        .addr      (q_addr),
        .mask      (q_mask),
        .base0     (q_base0),
        .base1     (q_base1),
        .valid     (out_valid),
        .line      (out_line),
        .line_addr (out_line_addr),
        .be        (out_be),
        .lane_en   (out_lane_en),
        .lane_off  (out_lane_off),
        .slot_addr (out_slot_addr)
    );

    assign out_wide  = q_wide;
    assign out_store = q_store;
endmodule

// File: rtl/cw_coalescer_chk.sv
module cw_coalescer_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_line,
    input logic          out_wide,
    input logic [AW-1:0] out_line_addr,
    input logic [63:0]   out_be,
    input logic [15:0]   out_lane_en
);
    logic [2:0] stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          stall <= '0;
        else if (in_ready)   stall <= '0;
        else if (stall != 3'd7) stall <= stall + 3'd1;
    end

    // R5: no quarter holds the input for more than three extra cycles
    assert_max_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall <= 3'd3);

    // R2: line requests always name a 64-byte aligned line
    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_line) |-> (out_line_addr[5:0] == 6'd0));

    // R3: a 64-bit line beat serves one half only
    assert_half_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_line && out_wide) |-> (out_lane_en[7:0] == 8'd0 || out_lane_en[15:8] == 8'd0));

    // R4: a per-lane beat stays within one group of four lanes and has no byte enables
    assert_scalar_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_line) |-> ($onehot({|out_lane_en[15:12], |out_lane_en[11:8],
                                              |out_lane_en[7:4], |out_lane_en[3:0]}) && out_be == 64'd0));

    // R6: byte enables cover exactly the element bytes of the enabled lanes
    assert_be_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_line) |-> ($countones(out_be) == (out_wide ? 8 : 4) * $countones(out_lane_en)));
endmodule

bind cw_coalescer cw_coalescer_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_line      (out_line),
    .out_wide      (out_wide),
    .out_line_addr (out_line_addr),
    .out_be        (out_be),
    .out_lane_en   (out_lane_en)
);

// File: tb/tb_cw_coalescer.sv
module tb_cw_coalescer;
    localparam int AW = 32;
    localparam int QL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_wide = 1'b0;
    logic              in_store = 1'b0;
    logic [QL-1:0]     in_mask = '0;
    logic [QL*AW-1:0]  in_addr = '0;
    logic              out_valid, out_line, out_wide, out_store;
    logic [AW-1:0]     out_line_addr;
    logic [63:0]       out_be;
    logic [QL-1:0]     out_lane_en;
    logic [QL*6-1:0]   out_lane_off;
    logic [4*AW-1:0]   out_slot_addr;

    cw_coalescer #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_wide(in_wide), .in_store(in_store), .in_mask(in_mask), .in_addr(in_addr),
        .out_valid(out_valid), .out_line(out_line), .out_wide(out_wide), .out_store(out_store),
        .out_line_addr(out_line_addr), .out_be(out_be), .out_lane_en(out_lane_en),
        .out_lane_off(out_lane_off), .out_slot_addr(out_slot_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [AW-1:0] qa [QL];
    logic [QL-1:0] qm;
    logic          qw, qs;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [AW-1:0] seg_base(input int s);
        int esz = qw ? 8 : 4;
        int n   = qw ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            int j = s * n + k;
            if (qm[j]) return qa[j] - AW'(k * esz);
        end
        return '0;
    endfunction

    function automatic bit packs();
        int esz = qw ? 8 : 4;
        int n   = qw ? 8 : 16;
        for (int s = 0; s < (qw ? 2 : 1); s++) begin
            logic [AW-1:0] b = seg_base(s);
            if (b[5:0] != 6'd0) return 0;
            for (int k = 0; k < n; k++) begin
                int j = s * n + k;
                if (qm[j] && qa[j] != b + AW'(k * esz)) return 0;
            end
        end
        return 1;
    endfunction

    function automatic int n_beats();
        return packs() ? (qw ? 2 : 1) : 4;
    endfunction

    task automatic make_pack(input bit w, input logic [QL-1:0] m, input bit st);
        int esz = w ? 8 : 4;
        int n   = w ? 8 : 16;
        qw = w; qm = m; qs = st;
        for (int s = 0; s < (w ? 2 : 1); s++) begin
            logic [AW-1:0] l = $urandom() & ~AW'(63);
            for (int k = 0; k < n; k++) begin
                int j = s * n + k;
                qa[j] = qm[j] ? l + AW'(k * esz) : AW'($urandom());
            end
        end
    endtask

    task automatic make_rand(input bit w, input logic [QL-1:0] m);
        qw = w; qm = m; qs = $urandom() & 1;
        for (int j = 0; j < QL; j++) qa[j] = $urandom();
    endtask

    task automatic drive();
        in_wide = qw; in_store = qs; in_mask = qm;
        for (int j = 0; j < QL; j++) in_addr[j*AW +: AW] = qa[j];
    endtask

    task automatic check_beat(input string tag, input int b);
        logic          e_line = 0;
        logic [AW-1:0] e_la = '0;
        logic [63:0]   e_be = '0;
        logic [QL-1:0] e_en = '0;
        logic [QL*6-1:0] e_off = '0;
        logic [4*AW-1:0] e_sa = '0;
        if (packs()) begin
            int esz = qw ? 8 : 4;
            int n   = qw ? 8 : 16;
            e_line = 1;
            e_la = seg_base(b);
            for (int k = 0; k < n; k++) begin
                int j = b * n + k;
                if (qm[j]) begin
                    e_en[j] = 1;
                    e_off[j*6 +: 6] = 6'(k * esz);
                    for (int y = 0; y < esz; y++) e_be[k*esz + y] = 1;
                end
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                int j = b * 4 + i;
                if (qm[j]) begin
                    e_en[j] = 1;
                    e_sa[i*AW +: AW] = qa[j];
                end
            end
        end
        chk({tag, " out_valid"}, out_valid, |e_en);
        if (|e_en) begin
            chk({tag, " out_line"}, out_line, e_line);
            chk({tag, " line_addr"}, out_line_addr, e_la);
            chk({tag, " be"}, out_be, e_be);
            chk({tag, " lane_en"}, out_lane_en, e_en);
            chk({tag, " lane_off"}, out_lane_off, e_off);
            chk({tag, " slot_addr"}, out_slot_addr, e_sa);
            chk({tag, " R9 out_wide"}, out_wide, qw);
            chk({tag, " R7 out_store"}, out_store, qs);
        end
    endtask

    // Called at a falling edge with the unit idle
    task automatic run_quarter(input string tag);
        int n = n_beats();
        chk({tag, " R5 ready before accept"}, in_ready, 1'b1);
        drive();
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        for (int b = 0; b < n; b++) begin
            check_beat(tag, b);
            chk({tag, " R5 ready on beat"}, in_ready, (b == n - 1));
            if (b < n - 1) @(negedge clk);
        end
        @(negedge clk);
        chk({tag, " R5 idle after quarter"}, {out_valid, in_ready}, 2'b01);
    endtask

    task automatic stream(input bit w, input bit pk, input string tag);
        int acc [5];
        int cnt = 0;
        bit rdy;
        for (int q = 0; q < 5; q++) begin
            if (q < 4) begin
                if (pk) make_pack(w, 16'hFFFF, 0);
                else    make_rand(w, 16'hFFFF);
            end else begin
                qw = 0; qm = '0; qs = 0;
            end
            drive();
            in_valid = 1;
            do begin
                rdy = in_ready;
                @(posedge clk);
                cnt++;
                @(negedge clk);
            end while (!rdy);
            acc[q] = cnt;
        end
        in_valid = 0;
        @(negedge clk);
        chk({tag, " wavefront cycles"}, acc[4] - acc[0], pk ? (w ? 8 : 4) : 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        chk("R1 reset out_valid", out_valid, 1'b0);
        chk("R1 reset in_ready", in_ready, 1'b1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 post-reset idle", {out_valid, in_ready}, 2'b01);

        // Directed corners
        make_pack(0, 16'hFFFF, 0);           run_quarter("R2 full 32-bit");
        make_pack(1, 16'hFFFF, 0);           run_quarter("R3 full 64-bit");
        make_pack(0, 16'h0000, 0);           run_quarter("R6 all disabled 32-bit");
        make_pack(1, 16'hFF00, 0);           run_quarter("R6 low half disabled 64-bit");
        make_pack(0, 16'hA5C3, 0);           run_quarter("R6 sparse mask garbage lanes");
        make_pack(0, 16'hFFFF, 1);           run_quarter("R7 store 32-bit");
        make_pack(1, 16'h0FF0, 1);           run_quarter("R7 store 64-bit");
        make_pack(0, 16'hFFFF, 0);
        for (int j = 0; j < QL; j++) qa[j] = qa[j] + 32'd16;
        run_quarter("R8 base 16-aligned only");
        make_pack(1, 16'hFFFF, 0);
        qa[11] = qa[11] + 32'd8;
        run_quarter("R8 one 64-bit lane displaced");
        make_rand(0, 16'hFFFF);              run_quarter("R4 scattered 32-bit");
        make_rand(1, 16'h0F0F);              run_quarter("R4 scattered masked 64-bit");

        // Constrained random mix
        for (int it = 0; it < 200; it++) begin
            int kind = $urandom_range(0, 3);
            bit w = $urandom() & 1;
            logic [QL-1:0] m = (($urandom() & 3) == 0) ? 16'hFFFF : QL'($urandom());
            case (kind)
                0: begin make_pack(w, m, $urandom() & 1); run_quarter(w ? "R3 random packed" : "R2 random packed"); end
                1: begin make_rand(w, m); run_quarter("R4 random scattered"); end
                2: begin
                    make_pack(w, m | 16'h0001, $urandom() & 1);
                    qa[0] = qa[0] + AW'(4 * $urandom_range(1, 3));
                    run_quarter("R8 random displaced lane");
                end
                default: begin
                    make_pack(w, m, 0);
                    for (int j = 0; j < QL; j++) qa[j] = qa[j] + 32'd32;
                    run_quarter("R8 random misaligned base");
                end
            endcase
        end

        stream(0, 1, "R5 32-bit packed");
        stream(1, 1, "R5 64-bit packed");
        stream(0, 0, "R5 32-bit unpacked");
        stream(1, 0, "R5 64-bit unpacked");

        finish_up();
    end
endmodule